// File: doc/BRIEF.md
# Ring-to-Idle Transition Sequencer

This controller sits on the host side of a solid-state ringing access switch and moves a telephone line from power ringing back to idle/talk. It drives two control lines of the switch: the state-select level (high selects ringing, low selects idle/talk) and an open-drain override that can pull the switch into an all-off state. Timing is counted in ticks of a millisecond strobe.

Two sequences are offered and picked per request by a mode input. In make-before-break mode the select line is dropped at once and the override stays released. The ringing contact can stay closed for up to half a ringing period after that, so completion is reported only after a programmed half-period wait. In break-before-make mode the override is pulled low first while select is still high, which forces all-off. Select then falls a fixed number of ticks later. After a programmed hold, which is clamped to at most 25 ticks, the override is released with select low. This closes the line break pair into idle/talk. A one-cycle done pulse marks completion, and busy covers the whole run.

Top module: `rts_ring_to_idle`

## Requirements
- R1: After reset, sel_ring is 1, sd_pull_low is 0, busy is 0 and done is 0.
- R2: With bbm_mode = 0, sel_ring is 0 in the cycle after an accepted stop_req, and sd_pull_low stays 0 for the whole run.
- R3: With bbm_mode = 0, done pulses on the clock edge that samples the N-th ms_tick after the request. N is half_ticks, and a value of 0 counts as 1.
- R4: With bbm_mode = 1, sd_pull_low is 1 in the cycle after an accepted stop_req, and sel_ring keeps its previous level there.
- R5: With bbm_mode = 1, sel_ring falls on the edge that samples the FALL_TICKS-th tick (default 3) after the request, while sd_pull_low is still 1.
- R6: With bbm_mode = 1, sd_pull_low is released and done pulses on the edge that samples the H-th tick. H is hold_ticks clamped to at most HOLD_MAX (default 25) and raised to at least FALL_TICKS+1. sel_ring is 0 at release.
- R7: sd_pull_low is never held across more than HOLD_MAX ticks.
- R8: A stop_req while busy is ignored. Mode and configuration are taken only from the accepted request.
- R9: done is high for exactly one cycle per run. busy is 1 from the cycle after acceptance and is 0 in the done cycle.
- R10: Once sel_ring has fallen it stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bbm_mode | input | 1 | 1 selects break-before-make, 0 selects make-before-break |
| stop_req | input | 1 | One-cycle ring-stop request |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| hold_ticks | input | CFG_W | All-off hold length in ticks (break-before-make) |
| half_ticks | input | CFG_W | Half ringing period in ticks (make-before-break) |
| sel_ring | output | 1 | Switch state-select level, 1 = ringing |
| sd_pull_low | output | 1 | 1 pulls the override line low, 0 releases it |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that ms_tick and stop_req are single-cycle strobes synchronous to clk. They also assume that reset is asserted from time zero. The bench respects this: it drives every strobe for one cycle at the falling clock edge, and it never raises a request on a cycle that also carries a tick. It resets the block before each table vector, so every run starts from the ringing level. It places the mid-run request that must be ignored on a cycle without a tick, with the mode and configuration flipped.

// File: rtl/rts_pkg.sv
package rts_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MBB  = 2'd1,
      ST_HOLD = 2'd2
   } seq_state_e;
endpackage

// File: rtl/rts_cfg_clamp.sv
module rts_cfg_clamp #(
   parameter int unsigned CFG_W      = 8,
   parameter int unsigned CNT_W      = 9,
   parameter int unsigned HOLD_MAX   = 25,
   parameter int unsigned FALL_TICKS = 3
) (
   input  logic [CFG_W-1:0] hold_raw,
   input  logic [CFG_W-1:0] half_raw,
   output logic [CNT_W-1:0] hold_eff,
   output logic [CNT_W-1:0] half_eff
);
   localparam int unsigned HOLD_MIN = FALL_TICKS + 1;
   localparam longint unsigned CFG_TOP = (64'd1 << CFG_W) - 1;

   logic [CNT_W-1:0] hold_w, half_w, hold_cap;

   assign hold_w = CNT_W'(hold_raw);
   assign half_w = CNT_W'(half_raw);

   // Clamp only when the field can exceed the legal hold (R6)
   generate
      if (CFG_TOP > HOLD_MAX) begin : g_cap
         assign hold_cap = (hold_w > CNT_W'(HOLD_MAX)) ? CNT_W'(HOLD_MAX) : hold_w;
      end else begin : g_nocap
         assign hold_cap = hold_w;
      end
   endgenerate

   assign hold_eff = (hold_cap < CNT_W'(HOLD_MIN)) ? CNT_W'(HOLD_MIN) : hold_cap;
   assign half_eff = (half_w == '0) ? CNT_W'(1) : half_w;

   always_comb begin
      p_hold_capped_r6: assert (hold_eff <= CNT_W'(HOLD_MAX) && hold_eff > CNT_W'(FALL_TICKS))
         else $error("hold out of range");
   end
endmodule

// File: rtl/rts_tick_cnt.sv
module rts_tick_cnt #(
   parameter int unsigned CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_next
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   assign cnt_next = cnt_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr)                   cnt_q <= '0;
      else if (inc && cnt_q != CNT_TOP) cnt_q <= cnt_next;
   end
endmodule

// File: rtl/rts_seq_fsm.sv
module rts_seq_fsm
   import rts_pkg::*;
#(
   parameter int unsigned CNT_W      = 9,
   parameter int unsigned HOLD_MAX   = 25,
   parameter int unsigned FALL_TICKS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             bbm,
   input  logic             tick,
   input  logic [CNT_W-1:0] hold_eff,
   input  logic [CNT_W-1:0] half_eff,
   input  logic [CNT_W-1:0] cnt_next,
   output logic             cnt_clr,
   output logic             cnt_inc,
   output logic             sel_q,
   output logic             sd_q,
   output logic             done_q,
   output logic             busy
);
   seq_state_e       st_q;
   logic [CNT_W-1:0] hold_r, half_r;
   logic             accept, at_fall, at_hold, at_half;

   assign accept  = (st_q == ST_IDLE) && req;   // R8: only idle accepts
   assign cnt_clr = accept;
   assign cnt_inc = (st_q != ST_IDLE) && tick;
   assign busy    = (st_q != ST_IDLE);

   assign at_fall = tick && (cnt_next == CNT_W'(FALL_TICKS));
   assign at_hold = tick && (cnt_next == hold_r);
   assign at_half = tick && (cnt_next == half_r);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         sel_q  <= 1'b1;
         sd_q   <= 1'b0;
         done_q <= 1'b0;
         hold_r <= '0;
         half_r <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (accept) begin
               hold_r <= hold_eff;
               half_r <= half_eff;
               if (bbm) begin
                  sd_q <= 1'b1;
                  st_q <= ST_HOLD;
               end else begin
                  sel_q <= 1'b0;
                  st_q  <= ST_MBB;
               end
            end
            ST_MBB: if (at_half) begin
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            ST_HOLD: begin
               if (at_fall) sel_q <= 1'b0;
               if (at_hold) begin
                  sd_q   <= 1'b0;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // Tick count while the override is held, used only by the R7 check
   logic [CNT_W-1:0] sd_ticks;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              sd_ticks <= '0;
      else if (!sd_q)          sd_ticks <= '0;
      else if (tick && sd_ticks != '1) sd_ticks <= sd_ticks + CNT_W'(1);
   end

   p_mbb_no_override_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MBB) |-> !sd_q);
   p_override_keeps_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sd_q) |-> $stable(sel_q));
   p_sel_falls_guarded_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_q) |-> (sd_q || st_q == ST_MBB));
   p_release_with_sel_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sd_q) |-> (!sel_q && done_q));
   p_hold_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sd_ticks <= CNT_W'(HOLD_MAX));
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   p_sel_no_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(sel_q));
endmodule

// File: rtl/rts_ring_to_idle.sv
module rts_ring_to_idle #(
   parameter int unsigned CFG_W      = 8,
   parameter int unsigned HOLD_MAX   = 25,
   parameter int unsigned FALL_TICKS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bbm_mode,
   input  logic             stop_req,
   input  logic             ms_tick,
   input  logic [CFG_W-1:0] hold_ticks,
   input  logic [CFG_W-1:0] half_ticks,
   output logic             sel_ring,
   output logic             sd_pull_low,
   output logic             busy,
   output logic             done
);
   localparam int unsigned CNT_W = CFG_W + 1;

   generate
      if (FALL_TICKS < 1 || FALL_TICKS >= HOLD_MAX) begin : g_bad_fall
         $error("FALL_TICKS must lie in 1..HOLD_MAX-1");
      end
      if (CFG_W < 2 || CFG_W > 24) begin : g_bad_width
         $error("CFG_W must lie in 2..24");
      end
   endgenerate

   logic [CNT_W-1:0] hold_eff, half_eff, cnt_q, cnt_next;
   logic             cnt_clr, cnt_inc;

   rts_cfg_clamp #(
      .CFG_W(CFG_W), .CNT_W(CNT_W), .HOLD_MAX(HOLD_MAX), .FALL_TICKS(FALL_TICKS)
   ) u_clamp (
      .hold_raw(hold_ticks), .half_raw(half_ticks),
      .hold_eff(hold_eff), .half_eff(half_eff)
   );

   rts_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
      .cnt_q(cnt_q), .cnt_next(cnt_next)
   );

   rts_seq_fsm #(
      .CNT_W(CNT_W), .HOLD_MAX(HOLD_MAX), .FALL_TICKS(FALL_TICKS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req(stop_req), .bbm(bbm_mode), .tick(ms_tick),
      .hold_eff(hold_eff), .half_eff(half_eff), .cnt_next(cnt_next),
      .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
      .sel_q(sel_ring), .sd_q(sd_pull_low), .done_q(done), .busy(busy)
   );
endmodule

// File: tb/tb_rts_ring_to_idle.sv
module tb_rts_ring_to_idle;
   localparam int CLK_PERIOD = 10;
   localparam int FALL = 3;
   localparam int HMAX = 25;
   localparam int NVEC = 10;

   // {bbm, hold, half, poke}
   localparam logic [17:0] VEC [NVEC] = '{
      {1'b0, 8'd0,   8'd10, 1'b0},
      {1'b0, 8'd0,   8'd0,  1'b0},
      {1'b0, 8'd7,   8'd1,  1'b0},
      {1'b1, 8'd10,  8'd0,  1'b0},
      {1'b1, 8'd25,  8'd3,  1'b0},
      {1'b1, 8'd40,  8'd3,  1'b0},
      {1'b1, 8'd255, 8'd0,  1'b0},
      {1'b1, 8'd2,   8'd9,  1'b0},
      {1'b1, 8'd6,   8'd2,  1'b1},
      {1'b0, 8'd3,   8'd20, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic bbm_mode = 1'b0, stop_req = 1'b0, ms_tick = 1'b0;
   logic [7:0] hold_ticks = '0, half_ticks = '0;
   logic sel_ring, sd_pull_low, busy, done;
   int ncheck = 0, nerr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rts_ring_to_idle #(.CFG_W(8), .HOLD_MAX(HMAX), .FALL_TICKS(FALL)) dut (
      .clk(clk), .rst_n(rst_n), .bbm_mode(bbm_mode), .stop_req(stop_req),
      .ms_tick(ms_tick), .hold_ticks(hold_ticks), .half_ticks(half_ticks),
      .sel_ring(sel_ring), .sd_pull_low(sd_pull_low), .busy(busy), .done(done)
   );

   task automatic chk(string req, int act, int exp);
      ncheck++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; stop_req = 1'b0; ms_tick = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 sel_ring", int'(sel_ring), 1);
      chk("R1 sd_pull_low", int'(sd_pull_low), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
   endtask

   task automatic run_vec(bit bbm, int hold, int half, bit poke);
      int ntick = 0, prev = 0, after = -1;
      int f_line = -1, f_sd = -1, f_rel = -1, f_done = -1, ndone = 0;
      int sel_at_sd = -1, busy0 = -1, busy_done = -1, sel_end = -1, busy_end = -1;
      int exp_half, exp_hold;
      exp_half = (half == 0) ? 1 : half;
      exp_hold = (hold > HMAX) ? HMAX : hold;
      if (exp_hold < FALL + 1) exp_hold = FALL + 1;

      stop_req = 1'b1; bbm_mode = bbm;
      hold_ticks = 8'(hold); half_ticks = 8'(half); ms_tick = 1'b0;
      for (int c = 0; c < 400 && after != 0; c++) begin
         @(negedge clk);
         ntick += prev;
         stop_req = 1'b0; bbm_mode = bbm;
         hold_ticks = 8'(hold); half_ticks = 8'(half);
         if (c == 0) busy0 = int'(busy);
         if (!sel_ring && f_line < 0) f_line = ntick;
         if (sd_pull_low && f_sd < 0) begin f_sd = ntick; sel_at_sd = int'(sel_ring); end
         if (f_sd >= 0 && !sd_pull_low && f_rel < 0) f_rel = ntick;
         if (done) begin
            ndone++;
            if (f_done < 0) begin f_done = ntick; busy_done = int'(busy); after = 6; end
         end
         if (after > 0) after--;
         if (after == 0) begin sel_end = int'(sel_ring); busy_end = int'(busy); end
         ms_tick = (c % 3 == 1);
         prev = int'(ms_tick);
         if (poke && c == 5) begin
            stop_req = 1'b1; bbm_mode = ~bbm; hold_ticks = 8'd1; half_ticks = 8'd1;
         end
      end
      ms_tick = 1'b0;

      if (!bbm) begin
         chk("R2 sel low tick", f_line, 0);
         chk("R2 override never pulled", f_sd, -1);
         chk("R3 done tick", f_done, exp_half);
      end else begin
         chk("R4 override tick", f_sd, 0);
         chk("R4 sel at override", sel_at_sd, 1);
         chk("R5 sel fall tick", f_line, FALL);
         chk("R6 release tick", f_rel, exp_hold);
         chk("R6 done tick", f_done, exp_hold);
         chk("R7 hold within limit", int'(f_rel <= HMAX), 1);
      end
      if (poke) chk("R8 busy request ignored", f_done, bbm ? exp_hold : exp_half);
      chk("R9 done count", ndone, 1);
      chk("R9 busy after accept", busy0, 1);
      chk("R9 busy at done", busy_done, 0);
      chk("R9 busy at end", busy_end, 0);
      chk("R10 sel stays low", sel_end, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", ncheck, nerr);
      $finish;
   end

   initial begin
      for (int v = 0; v < NVEC; v++) begin
         do_reset();
         run_vec(VEC[v][17], int'(VEC[v][16:9]), int'(VEC[v][8:1]), VEC[v][0]);
      end

      // R1: reset during an all-off hold returns to the ringing level
      do_reset();
      stop_req = 1'b1; bbm_mode = 1'b1; hold_ticks = 8'd20;
      @(negedge clk); stop_req = 1'b0;
      for (int c = 0; c < 20; c++) begin
         ms_tick = (c % 3 == 1);
         @(negedge clk);
      end
      ms_tick = 1'b0;
      chk("R4 override held mid-run", int'(sd_pull_low), 1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 sel after mid-run reset", int'(sel_ring), 1);
      chk("R1 override after mid-run reset", int'(sd_pull_low), 0);
      chk("R1 busy after mid-run reset", int'(busy), 0);
      rst_n = 1'b1;

      // R10: a second make-before-break run keeps sel low and completes
      do_reset();
      run_vec(1'b0, 0, 2, 1'b0);
      run_vec(1'b0, 0, 4, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", ncheck, nerr);
      $finish;
   end
endmodule